// File: doc/BRIEF.md
# Banked Scratchpad Conflict Arbiter

This block schedules the read requests of one warp against a scratchpad whose words are interleaved across 32 banks. A warp hands over up to 32 lane requests at once: one word address per lane, a mask of active lanes, and a word-size mode. The arbiter works out each lane's bank and the row inside that bank. It then issues a sequence of grant cycles. In each cycle every bank opens at most one row, and every pending lane that wants exactly that row is served by the same bank read. This covers broadcast, where all lanes read one word, and multicast, where groups of lanes share words.

Lanes that want different rows of one bank are spread over extra cycles. The total number of grant cycles therefore equals the worst per-bank count of distinct rows. The block raises `done` in the cycle that serves the last lane. It takes a new warp only when idle, through a valid/ready handshake. The SRAM arrays and the write path are outside this block. The grant outputs steer the read side of those arrays.

Top module: `bank_conflict_arb`

## Requirements
- R1: In 32-bit word mode (`req_wide`=0) the word index of a lane is its address. Its bank is the index modulo 32 (bits [4:0]) and its row is the index divided by 32 (bits [15:5]). Address 32 therefore lands in bank 0, row 1. The row of bank b appears on `gnt_bank_row[b*11 +: 11]`.
- R2: In 64-bit word mode (`req_wide`=1) address bit 0 is dropped before the mapping of R1. Addresses 2k and 2k+1 name the same word and share one bank read.
- R3: When every active lane falls in a different bank, all of them are granted in the single cycle after acceptance, and `done` is high in that cycle.
- R4: Lanes that read the same word are granted in the same cycle. Only one row of that bank is opened for them.
- R5: In one grant cycle each bank opens at most one row. Lanes naming other rows of that bank stay pending.
- R6: For each bank, the lowest-numbered pending lane mapped to it picks the row. Every pending lane of that bank with the same row is granted alongside it.
- R7: The number of grant cycles of a warp equals the largest number of distinct rows requested in any one bank.
- R8: Lanes whose `req_mask` bit is 0 are never granted and never cause conflicts. An all-zero mask gives `done`=1 with `gnt_valid`=0 in the cycle after acceptance.
- R9: `req_ready` is high when idle. A warp is taken on the edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from then through the `done` cycle and rises in the next cycle. Requests offered while busy are ignored.
- R10: After reset `req_ready`=1, `gnt_valid`=0, `done`=0 and all bank enables are 0.
- R11: Grants start in the cycle after acceptance. Each active lane is granted exactly once per warp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A warp request is offered |
| req_ready | output | 1 | Arbiter is idle and will take a warp |
| req_mask | input | 32 | Active lanes of the offered warp |
| req_addr | input | 512 | Lane word addresses, lane i at [i*16 +: 16] |
| req_wide | input | 1 | 0 = 32-bit words, 1 = 64-bit words |
| gnt_valid | output | 1 | At least one lane is granted this cycle |
| gnt_mask | output | 32 | Lanes served this cycle |
| gnt_bank_en | output | 32 | Banks read this cycle |
| gnt_bank_row | output | 352 | Row per bank, bank b at [b*11 +: 11], zero when not read |
| done | output | 1 | Last grant cycle of the warp (or the empty-warp cycle) |

## Verification
The bench targets a full 32-way single-bank conflict, where a design that merged rows would finish early and one that dropped the leader would hang. It also covers a full broadcast, where a design without merging would take 32 cycles instead of one. A priority case checks that the row is picked by the lowest lane and not the highest, so an inverted priority search shows up in the first grant mask. Inactive lanes that collide with active ones and the empty mask expose designs that consult the mask only at the edge. The 64-bit mode exposes a bank mapping that forgets to drop address bit 0. A request held through a busy warp shows whether a second acceptance would corrupt the pending set.

// File: rtl/bca_pkg.sv
package bca_pkg;

    localparam int unsigned DEF_LANES = 32;
    localparam int unsigned DEF_BANKS = 32;
    localparam int unsigned DEF_AW    = 16;

    // word size selection: picks how an address folds into a bank word
    typedef enum logic {
        WORD_NARROW = 1'b0,
        WORD_WIDE   = 1'b1
    } word_mode_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SERVE = 1'b1
    } warp_state_e;

endpackage

// File: rtl/bca_lane_map.sv
module bca_lane_map
    import bca_pkg::*;
#(
    parameter int unsigned AW    = DEF_AW,
    parameter int unsigned BANKS = DEF_BANKS,
    localparam int unsigned BW   = $clog2(BANKS),
    localparam int unsigned RW   = AW - BW
) (
    input  logic [AW-1:0] addr,
    input  word_mode_e    mode,
    output logic [BW-1:0] bank,
    output logic [RW-1:0] row
);

    logic [AW-1:0] word_idx;

    always_comb begin
        // wide words occupy two address units, so the unit bit is dropped
        if (mode == WORD_WIDE) begin
            word_idx = {1'b0, addr[AW-1:1]};
        end else begin
            word_idx = addr;
        end
        bank = word_idx[BW-1:0];
        row  = word_idx[AW-1:BW];
    end

endmodule

// File: rtl/bca_bank_pick.sv
module bca_bank_pick #(
    parameter int unsigned LANES   = 32,
    parameter int unsigned BANKS   = 32,
    parameter int unsigned AW      = 16,
    parameter int unsigned BANK_ID = 0,
    localparam int unsigned BW     = $clog2(BANKS),
    localparam int unsigned RW     = AW - BW
) (
    input  logic [LANES-1:0]    pending,
    input  logic [LANES*BW-1:0] lane_bank,
    input  logic [LANES*RW-1:0] lane_row,
    output logic                en,
    output logic [RW-1:0]       row
);

    localparam logic [BW-1:0] MY_BANK = BW'(BANK_ID);

    // scan from the top so the lowest pending lane of this bank wins
    always_comb begin
        en  = 1'b0;
        row = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (pending[i] && (lane_bank[i*BW +: BW] == MY_BANK)) begin
                en  = 1'b1;
                row = lane_row[i*RW +: RW];
            end
        end
    end

endmodule

// File: rtl/bca_warp_ctrl.sv
module bca_warp_ctrl
    import bca_pkg::*;
#(
    parameter int unsigned LANES = DEF_LANES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [LANES-1:0] req_mask,
    input  logic [LANES-1:0] gnt,
    output logic             req_ready,
    output logic             accept,
    output logic [LANES-1:0] pending,
    output logic             gnt_valid,
    output logic             done
);

    warp_state_e      state_q;
    logic [LANES-1:0] pending_q;
    logic [LANES-1:0] left_after;

    assign req_ready  = (state_q == ST_IDLE);
    assign accept     = req_valid && req_ready;
    assign pending    = pending_q;
    assign left_after = pending_q & ~gnt;
    assign gnt_valid  = (state_q == ST_SERVE) && (pending_q != '0);
    assign done       = (state_q == ST_SERVE) && (left_after == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            pending_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        state_q   <= ST_SERVE;
                        pending_q <= req_mask;
                    end
                end
                ST_SERVE: begin
                    pending_q <= left_after;
                    if (left_after == '0) begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R8 / R11: only lanes still waiting may be served
    assert_grant_in_pending_R8: assert property (@(posedge clk) disable iff (rst)
        (gnt & ~pending_q) == '0);

    // R7: while lanes wait, every cycle serves at least one of them
    assert_progress_R7: assert property (@(posedge clk) disable iff (rst)
        gnt_valid |-> (gnt != '0));

    // R9: the done cycle closes the warp and reopens the request side
    assert_done_reopens_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> (req_ready && !gnt_valid));

    // R9: the waiting set only shrinks while a warp is served
    assert_no_new_lanes_R9: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SERVE && !done) |=> ((pending_q & ~$past(pending_q)) == '0));

endmodule

// File: rtl/bank_conflict_arb.sv
module bank_conflict_arb
    import bca_pkg::*;
#(
    parameter int unsigned LANES = DEF_LANES,
    parameter int unsigned BANKS = DEF_BANKS,
    parameter int unsigned AW    = DEF_AW,
    localparam int unsigned BW   = $clog2(BANKS),
    localparam int unsigned RW   = AW - BW
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [LANES-1:0]    req_mask,
    input  logic [LANES*AW-1:0] req_addr,
    input  logic                req_wide,
    output logic                gnt_valid,
    output logic [LANES-1:0]    gnt_mask,
    output logic [BANKS-1:0]    gnt_bank_en,
    output logic [BANKS*RW-1:0] gnt_bank_row,
    output logic                done
);

    logic                accept;
    logic [LANES-1:0]    pending;
    logic [LANES*AW-1:0] addr_q;
    word_mode_e          mode_q;
    logic [LANES*BW-1:0] lane_bank;
    logic [LANES*RW-1:0] lane_row;

    // the warp's addresses are held for all of its grant cycles
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            mode_q <= WORD_NARROW;
        end else if (accept) begin
            addr_q <= req_addr;
            mode_q <= word_mode_e'(req_wide);
        end
    end

    bca_warp_ctrl #(.LANES(LANES)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_mask  (req_mask),
        .gnt       (gnt_mask),
        .req_ready (req_ready),
        .accept    (accept),
        .pending   (pending),
        .gnt_valid (gnt_valid),
        .done      (done)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        bca_lane_map #(.AW(AW), .BANKS(BANKS)) u_map (
            .addr (addr_q[l*AW +: AW]),
            .mode (mode_q),
            .bank (lane_bank[l*BW +: BW]),
            .row  (lane_row[l*RW +: RW])
        );
    end

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        bca_bank_pick #(.LANES(LANES), .BANKS(BANKS), .AW(AW), .BANK_ID(b)) u_pick (
            .pending   (pending),
            .lane_bank (lane_bank),
            .lane_row  (lane_row),
            .en        (gnt_bank_en[b]),
            .row       (gnt_bank_row[b*RW +: RW])
        );
    end

    // a lane rides along whenever its bank opened the row it wants
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            gnt_mask[i] = pending[i]
                && gnt_bank_en[lane_bank[i*BW +: BW]]
                && (gnt_bank_row[int'(lane_bank[i*BW +: BW])*RW +: RW] == lane_row[i*RW +: RW]);
        end
    end

    // R6: the lowest waiting lane is always among those served
    assert_leader_served_R6: assert property (@(posedge clk) disable iff (rst)
        gnt_valid |-> (((pending & (~pending + 1'b1)) & ~gnt_mask) == '0));

    // R5: no bank is read unless a granted lane needs it
    assert_bank_has_user_R5: assert property (@(posedge clk) disable iff (rst)
        (gnt_bank_en != '0) |-> (gnt_mask != '0));

endmodule

// File: tb/sim_bank_conflict_arb.sv
`timescale 1ns/1ps
module sim_bank_conflict_arb;

    localparam int L  = 32;
    localparam int NB = 32;
    localparam int AW = 16;
    localparam int RW = 11;

    logic            clk = 1'b0;
    logic            rst;
    logic            req_valid;
    logic            req_ready;
    logic [L-1:0]    req_mask;
    logic [L*AW-1:0] req_addr;
    logic            req_wide;
    logic            gnt_valid;
    logic [L-1:0]    gnt_mask;
    logic [NB-1:0]   gnt_bank_en;
    logic [NB*RW-1:0] gnt_bank_row;
    logic            done;

    int tests = 0;
    int fails = 0;
    int clk_count = 0;
    int sa [L];

    always #4 clk = ~clk;

    bank_conflict_arb u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_mask(req_mask), .req_addr(req_addr), .req_wide(req_wide),
        .gnt_valid(gnt_valid), .gnt_mask(gnt_mask), .gnt_bank_en(gnt_bank_en),
        .gnt_bank_row(gnt_bank_row), .done(done)
    );

    always @(posedge clk) begin
        clk_count++;
        if (clk_count > 150000) begin
            fails++;
            tests++;
            $display("FAIL watchdog: got %0d cycles expected fewer", clk_count);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string what, input logic [NB*RW-1:0] act,
                       input logic [NB*RW-1:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", what, act, exp);
        end
    endtask

    function automatic int wrd(input int a, input bit w);
        return w ? (a / 2) : a;
    endfunction

    // run one warp, comparing every cycle against a sequential reference
    task automatic run_warp(input logic [L-1:0] m, input bit w, input bit hold, input string tag);
        int ma [L];
        int pend [L];
        int claimed [NB];
        int crow [NB];
        logic [L-1:0] egnt, seen;
        logic [NB-1:0] een;
        logic [NB*RW-1:0] erow;
        int cyc, maxd, bk, rw;
        bit fin, edone;
        for (int i = 0; i < L; i++) ma[i] = sa[i];
        // expected cycle count: worst distinct rows per bank
        maxd = 0;
        for (int b = 0; b < NB; b++) begin
            int cnt = 0;
            for (int i = 0; i < L; i++) begin
                bit fresh = m[i] && (wrd(ma[i], w) % NB == b);
                for (int j = 0; j < i; j++)
                    if (fresh && m[j] && wrd(ma[j], w) == wrd(ma[i], w)) fresh = 0;
                if (fresh) cnt++;
            end
            if (cnt > maxd) maxd = cnt;
        end
        @(negedge clk);
        chk(req_ready == 1'b1, {tag, " R9 ready before offer"}, NB*RW'(req_ready), 1);
        req_valid = 1'b1;
        req_mask  = m;
        req_wide  = w;
        for (int i = 0; i < L; i++) req_addr[i*AW +: AW] = ma[i][AW-1:0];
        @(negedge clk);
        if (hold) begin
            // a second request offered while busy must change nothing
            req_mask = ~m;
            req_wide = ~w;
            for (int i = 0; i < L; i++) req_addr[i*AW +: AW] = 16'(i * 7);
        end else begin
            req_valid = 1'b0;
        end
        for (int i = 0; i < L; i++) pend[i] = m[i];
        seen = '0;
        cyc = 0;
        fin = 0;
        while (!fin && cyc < 100) begin
            for (int b = 0; b < NB; b++) begin claimed[b] = 0; crow[b] = 0; end
            egnt = '0;
            een = '0;
            erow = '0;
            for (int i = 0; i < L; i++) begin
                if (pend[i] != 0) begin
                    bk = wrd(ma[i], w) % NB;
                    rw = wrd(ma[i], w) / NB;
                    if (claimed[bk] == 0) begin
                        claimed[bk] = 1;
                        crow[bk] = rw;
                        een[bk] = 1'b1;
                        erow[bk*RW +: RW] = RW'(rw);
                    end
                    if (crow[bk] == rw) egnt[i] = 1'b1;
                end
            end
            edone = 1;
            for (int i = 0; i < L; i++) if (pend[i] != 0 && !egnt[i]) edone = 0;
            chk(gnt_mask == egnt, {tag, " R6 gnt_mask"}, NB*RW'(gnt_mask), NB*RW'(egnt));
            chk(gnt_bank_en == een, {tag, " R5 gnt_bank_en"}, NB*RW'(gnt_bank_en), NB*RW'(een));
            chk(gnt_bank_row == erow, {tag, " R1 gnt_bank_row"}, gnt_bank_row, erow);
            chk(gnt_valid == (m != '0), {tag, " R11 gnt_valid"}, NB*RW'(gnt_valid), NB*RW'(m != '0));
            chk(done == edone, {tag, " R7 done"}, NB*RW'(done), NB*RW'(edone));
            chk(req_ready == 1'b0, {tag, " R9 ready while busy"}, NB*RW'(req_ready), 0);
            chk((seen & gnt_mask) == '0, {tag, " R11 lane granted twice"},
                NB*RW'(seen & gnt_mask), 0);
            seen = seen | gnt_mask;
            for (int i = 0; i < L; i++) if (egnt[i]) pend[i] = 0;
            cyc++;
            if (edone) begin
                fin = 1;
                req_valid = 1'b0;
            end else begin
                @(negedge clk);
            end
        end
        if (m != '0)
            chk(cyc == maxd, {tag, " R7 cycle count"}, NB*RW'(cyc), NB*RW'(maxd));
        else
            chk(cyc == 1, {tag, " R8 empty warp cycles"}, NB*RW'(cyc), 1);
        chk(seen == m, {tag, " R11 lanes served"}, NB*RW'(seen), NB*RW'(m));
        @(negedge clk);
        chk(req_ready == 1'b1 && gnt_valid == 1'b0, {tag, " R9 idle after done"},
            NB*RW'({req_ready, gnt_valid}), NB*RW'(2'b10));
    endtask

    initial begin
        int unsigned s;
        rst = 1'b1;
        req_valid = 1'b0;
        req_mask = '0;
        req_addr = '0;
        req_wide = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        chk(req_ready == 1'b1, "R10 ready", NB*RW'(req_ready), 1);
        chk(gnt_valid == 1'b0 && done == 1'b0, "R10 gnt_valid/done", NB*RW'({gnt_valid, done}), 0);
        chk(gnt_bank_en == '0, "R10 bank_en", NB*RW'(gnt_bank_en), 0);

        // R3 / R1: consecutive words, each lane in its own bank
        for (int i = 0; i < L; i++) sa[i] = 64 + i;
        run_warp('1, 1'b0, 1'b0, "R3 stride1");

        // R4: all lanes read one word
        for (int i = 0; i < L; i++) sa[i] = 5;
        run_warp('1, 1'b0, 1'b0, "R4 broadcast");

        // R5 / R7 / R9: 32 rows in bank 0, request held while busy
        for (int i = 0; i < L; i++) sa[i] = i * 32;
        run_warp('1, 1'b0, 1'b1, "R5 stride32 hold");

        // R7: two rows per even bank
        for (int i = 0; i < L; i++) sa[i] = 2 * i;
        run_warp('1, 1'b0, 1'b0, "R7 stride2");

        // R4 multicast groups mixed with conflicts
        for (int i = 0; i < L; i++) sa[i] = ((i * 7) % 5) * 32 + (i % 3);
        run_warp('1, 1'b0, 1'b0, "R4 multicast");

        // R6: lane 0 picks row 1 of bank 3, lane 1 waits for row 0
        for (int i = 0; i < L; i++) sa[i] = 0;
        sa[0] = 32 + 3; sa[1] = 3; sa[2] = 32 + 3;
        run_warp(32'h0000_0007, 1'b0, 1'b0, "R6 priority");

        // R8: empty mask
        run_warp('0, 1'b0, 1'b0, "R8 empty");

        // R8: inactive odd lanes would collide with active even lanes
        for (int i = 0; i < L; i++) sa[i] = (i % 2 == 0) ? i : (i - 1) + 32 * 5;
        run_warp(32'h5555_5555, 1'b0, 1'b0, "R8 sparse");

        // R2: wide words, address pairs share a word
        for (int i = 0; i < L; i++) sa[i] = i;
        run_warp('1, 1'b1, 1'b0, "R2 wide pairs");
        for (int i = 0; i < L; i++) sa[i] = i * 64 + 1;
        run_warp('1, 1'b1, 1'b0, "R2 wide stride");
        for (int i = 0; i < L; i++) sa[i] = i * 2;
        run_warp('1, 1'b1, 1'b0, "R2 wide distinct");

        // pseudo-random warps in both modes
        s = 32'h1234_5678;
        for (int k = 0; k < 40; k++) begin
            logic [L-1:0] mk;
            for (int i = 0; i < L; i++) begin
                s = s * 1103515245 + 12345;
                sa[i] = int'((s >> 8) & 32'h0000_07FF);
            end
            s = s * 1103515245 + 12345;
            mk = (k % 4 == 0) ? '1 : L'(s ^ (s << 7));
            run_warp(mk, k[0], k[2], "R1 random");
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule